// File: doc/BRIEF.md
# GPIO Port Controller

This block controls one port of 32 general-purpose pins through a small word-addressed register window of 0x200 bytes. For every pin it stores whether GPIO logic or an on-chip peripheral owns the pad, which of seven peripheral functions is routed when a peripheral owns it, the output enable and output level used under GPIO ownership, the pull-up, pull-down and Schmitt-trigger enables for the pad cell, and the interrupt enable and edge selection. Software changes individual bits without a read-modify-write: each configuration group has four consecutive words that write, set, clear or toggle only the bits written as 1.

The pin inputs pass through a two-flop synchronizer. A third flop holds the previous synchronized level, so rising and falling transitions can be detected. A detected transition of the selected kind latches a per-pin flag, which stays set until software clears it. The combined interrupt line is high while any flag is set whose enable bit is also set. The pad output and pad output-enable come from a registered per-pin multiplexer that picks either the GPIO registers or the selected peripheral lane.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every configuration group reads 0, except the GPIO ownership group, which reads all ones. The read data, the interrupt line, pad_out and pad_oe are all 0.
- R2: For a group at base offset B, a write to B stores the data, a write to B+4 sets the bits written as 1, a write to B+8 clears them, and a write to B+C inverts them. Bits written as 0 keep their value. Reads of B+4, B+8 and B+C return 0.
- R3: The groups sit at these base offsets: ownership 0x00, function planes 0x10 (code bit 0), 0x20 (bit 1) and 0x30 (bit 2), output enable 0x40, output level 0x50, pull-up 0x70, pull-down 0x80, interrupt enable 0x90, edge mode low bit 0xA0, edge mode high bit 0xB0, filter storage 0xC0, Schmitt 0x160. Each group reads back the value it holds.
- R4: The read-only word at 0x60 returns the level of every pin after two synchronizing flops. Writes to 0x60 have no effect.
- R5: The edge code of a pin is {bit at 0xB0, bit at 0xA0}. Code 01 flags only rising transitions, code 10 flags only falling transitions, and codes 00 and 11 flag both.
- R6: A pin's flag reads at 0xD0. It sets in the cycle after its synchronized level makes a selected transition, and it stays set until software writes 1 to that bit at 0xD8. Writes to 0xD0, 0xD4 and 0xDC have no effect. When a flag sets and is cleared in the same cycle, the set wins.
- R7: irq goes high one cycle after any pin has both its flag and its interrupt enable set. irq is 0 one cycle after no enabled flag remains.
- R8: A pin owned by GPIO (ownership bit 1) drives pad_out from its output-level bit and pad_oe from its output-enable bit. The pad outputs follow one cycle after the register change.
- R9: A pin owned by a peripheral (ownership bit 0) drives pad_out and pad_oe from lane f of that pin in periph_dout and periph_oe, which sit at bit pin*7+f. Here f is the 3-bit function code. Code 7 drives both outputs to 0.
- R10: The outputs pull_up, pull_dn and schmitt_en reflect the pull-up, pull-down and Schmitt groups bit for bit.
- R11: Unmapped offsets read 0. Offset 0x1F8 reads the pin count (32) and 0x1FC reads the version constant (0x00010200). Writes to either word have no effect.
- R12: bus_rdata is registered. It changes only at the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address in the window (bits 1:0 ignored) |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| periph_dout | input | 224 | Peripheral output lanes, 7 per pin |
| periph_oe | input | 224 | Peripheral output-enable lanes, 7 per pin |
| pad_out | output | 32 | Level driven to each pad |
| pad_oe | output | 32 | Pad driver enable |
| pull_up | output | 32 | Pull-up enable per pad |
| pull_dn | output | 32 | Pull-down enable per pad |
| schmitt_en | output | 32 | Input Schmitt enable per pad |
| irq | output | 1 | Combined interrupt |

## Verification
The bench walks every configuration group through store, set, clear and toggle with distinct data words, so a wrong alias decode or a wrong group base shows up as a wrong arithmetic result. The edge logic is tried with all four mode codes against both a rising and a falling pin transition. This separates the code mapping and the treatment of code 11. A clear write placed in the same cycle as a flag set shows which of the two wins. The pad multiplexer is swept over all eight function codes with one-hot and inverted one-hot lane patterns, so a bit-plane swap or an off-by-one lane shows up. Ownership and output-enable patterns check which source drives the pad.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int WIN_AW  = 9;
  localparam int FSEL_W  = 3;
  localparam int NUM_CFG = 13;

  localparam int G_OWN = 0;
  localparam int G_FP0 = 1;
  localparam int G_FP1 = 2;
  localparam int G_FP2 = 3;
  localparam int G_OEN = 4;
  localparam int G_OLV = 5;
  localparam int G_PUP = 6;
  localparam int G_PDN = 7;
  localparam int G_IEN = 8;
  localparam int G_ML  = 9;
  localparam int G_MH  = 10;
  localparam int G_FLT = 11;
  localparam int G_SCH = 12;

  localparam logic [WIN_AW-1:0] OFS_PINLVL = 9'h060;
  localparam logic [WIN_AW-1:0] OFS_FLAG   = 9'h0D0;
  localparam logic [WIN_AW-1:0] OFS_FLGCLR = 9'h0D8;
  localparam logic [WIN_AW-1:0] OFS_NPINS  = 9'h1F8;
  localparam logic [WIN_AW-1:0] OFS_VER    = 9'h1FC;

  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TGL   = 2'd3
  } alias_op_e;

  function automatic logic [WIN_AW-1:0] cfg_base(input int g);
    case (g)
      G_OWN:   cfg_base = 9'h000;
      G_FP0:   cfg_base = 9'h010;
      G_FP1:   cfg_base = 9'h020;
      G_FP2:   cfg_base = 9'h030;
      G_OEN:   cfg_base = 9'h040;
      G_OLV:   cfg_base = 9'h050;
      G_PUP:   cfg_base = 9'h070;
      G_PDN:   cfg_base = 9'h080;
      G_IEN:   cfg_base = 9'h090;
      G_ML:    cfg_base = 9'h0A0;
      G_MH:    cfg_base = 9'h0B0;
      G_FLT:   cfg_base = 9'h0C0;
      default: cfg_base = 9'h160;
    endcase
  endfunction
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_port_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  alias_op_e    op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (hit) begin
      case (op)
        OP_STORE: q <= wdata;
        OP_SET:   q <= q | wdata;
        OP_CLR:   q <= q & ~wdata;
        default:  q <= q ^ wdata;
      endcase
    end
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));

  assert_clr_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && op == OP_CLR) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] mode_lo,
  input  logic [W-1:0] mode_hi,
  input  logic [W-1:0] irq_en,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] level,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] meta_q, sync_q, prev_q, flag_q;
  logic [W-1:0] rise, fall, take_rise, take_fall, hit, drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    rise      = sync_q & ~prev_q;
    fall      = ~sync_q & prev_q;
    take_rise = ~(mode_hi & ~mode_lo);
    take_fall = ~(mode_lo & ~mode_hi);
    hit       = (rise & take_rise) | (fall & take_fall);
    drop      = clr_we ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~drop) | hit;
      irq    <= |(flag_q & irq_en);
    end
  end

  assign level = sync_q;
  assign flags = flag_q;

  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> (($past(flag_q) & ~flag_q) == '0));

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_en) == '0) |-> !irq);
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_port_pkg::*;
#(
  parameter int W  = 32,
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  gpio_own,
  input  logic [W-1:0]  out_en,
  input  logic [W-1:0]  out_lvl,
  input  logic [W-1:0]  fp0,
  input  logic [W-1:0]  fp1,
  input  logic [W-1:0]  fp2,
  input  logic [W*NF-1:0] periph_dout,
  input  logic [W*NF-1:0] periph_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe
);
  localparam int LANES = 1 << FSEL_W;

  logic [W-1:0] nxt_out, nxt_oe;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [FSEL_W-1:0] fsel;
    logic [LANES-1:0]  d_lane, e_lane;
    assign fsel   = {fp2[i], fp1[i], fp0[i]};
    assign d_lane = LANES'(periph_dout[i*NF +: NF]);
    assign e_lane = LANES'(periph_oe[i*NF +: NF]);
    assign nxt_out[i] = gpio_own[i] ? out_lvl[i] : d_lane[fsel];
    assign nxt_oe[i]  = gpio_own[i] ? out_en[i]  : e_lane[fsel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

  assert_gpio_input_undriven_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(gpio_own & ~out_en)) == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NFUNC = 7,
  parameter int DW    = 32,
  parameter logic [DW-1:0] VERSION = 32'h0001_0200
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WIN_AW-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NPINS-1:0]       pin_in,
  input  logic [NPINS*NFUNC-1:0] periph_dout,
  input  logic [NPINS*NFUNC-1:0] periph_oe,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       pull_up,
  output logic [NPINS-1:0]       pull_dn,
  output logic [NPINS-1:0]       schmitt_en,
  output logic                   irq
);
  logic [NPINS-1:0] cfg_q [NUM_CFG];
  logic [NPINS-1:0] pin_lvl, flag_vec;
  logic [WIN_AW-1:0] word_addr;
  logic flag_clr_we;
  logic [DW-1:0] rd_next;
  logic unused_addr_lsb;

  assign word_addr       = {bus_addr[WIN_AW-1:2], 2'b00};
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign flag_clr_we     = bus_we && (word_addr == OFS_FLGCLR);

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam logic [WIN_AW-1:0] BASE = cfg_base(g);
    localparam logic [NPINS-1:0]  RV   = (g == G_OWN) ? {NPINS{1'b1}} : '0;
    logic hit;
    assign hit = bus_we && (bus_addr[WIN_AW-1:4] == BASE[WIN_AW-1:4]);
    gpio_alias_reg #(.W(NPINS), .RST_VAL(RV)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .hit   (hit),
      .op    (alias_op_e'(bus_addr[3:2])),
      .wdata (bus_wdata[NPINS-1:0]),
      .q     (cfg_q[g])
    );
  end

  gpio_edge_irq #(.W(NPINS)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .mode_lo  (cfg_q[G_ML]),
    .mode_hi  (cfg_q[G_MH]),
    .irq_en   (cfg_q[G_IEN]),
    .clr_we   (flag_clr_we),
    .clr_mask (bus_wdata[NPINS-1:0]),
    .level    (pin_lvl),
    .flags    (flag_vec),
    .irq      (irq)
  );

  gpio_pad_mux #(.W(NPINS), .NF(NFUNC)) u_pad (
    .clk         (clk),
    .rst         (rst),
    .gpio_own    (cfg_q[G_OWN]),
    .out_en      (cfg_q[G_OEN]),
    .out_lvl     (cfg_q[G_OLV]),
    .fp0         (cfg_q[G_FP0]),
    .fp1         (cfg_q[G_FP1]),
    .fp2         (cfg_q[G_FP2]),
    .periph_dout (periph_dout),
    .periph_oe   (periph_oe),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
  );

  assign pull_up    = cfg_q[G_PUP];
  assign pull_dn    = cfg_q[G_PDN];
  assign schmitt_en = cfg_q[G_SCH];

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NUM_CFG; g++) begin
      if (word_addr == cfg_base(g)) rd_next = DW'(cfg_q[g]);
    end
    if (word_addr == OFS_PINLVL) rd_next = DW'(pin_lvl);
    if (word_addr == OFS_FLAG)   rd_next = DW'(flag_vec);
    if (word_addr == OFS_NPINS)  rd_next = DW'(NPINS);
    if (word_addr == OFS_VER)    rd_next = VERSION;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assert_rdata_registered_R12: assert property (@(posedge clk) disable iff (rst)
    $stable(rd_next) |=> (bus_rdata == $past(rd_next)));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  localparam int NP = 32;
  localparam int NF = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP*NF-1:0] periph_dout = '0;
  logic [NP*NF-1:0] periph_oe = '0;
  logic [NP-1:0] pad_out, pad_oe, pull_up, pull_dn, schmitt_en;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .periph_dout(periph_dout), .periph_oe(periph_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn),
    .schmitt_en(schmitt_en), .irq(irq)
  );

  int cfg_ofs [13] = '{'h000, 'h010, 'h020, 'h030, 'h040, 'h050, 'h070,
                       'h080, 'h090, 'h0A0, 'h0B0, 'h0C0, 'h160};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 9'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 9'(a); bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b, c, d, e;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    for (int g = 0; g < 13; g++) begin
      rd(cfg_ofs[g], v);
      chk("R1 reset group", v, (g == 0) ? 32'hFFFF_FFFF : 32'h0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pad_oe", pad_oe, 32'd0);
    chk("R1 pad_out", pad_out, 32'd0);

    // R2 R3: alias arithmetic on every group
    for (int g = 0; g < 13; g++) begin
      a = 32'hA5C3_0F96 ^ (32'h0101_0101 * 32'(g));
      b = 32'h1248_8421 << (g % 4);
      c = 32'h00FF_F00F ^ (32'h1111_0000 * 32'(g));
      d = 32'hF0F0_3C3C >> (g % 3);
      wr(cfg_ofs[g], a);
      rd(cfg_ofs[g], v); chk("R3 store readback", v, a);
      e = a | b;
      wr(cfg_ofs[g] + 4, b);
      rd(cfg_ofs[g], v); chk("R2 set alias", v, e);
      e = e & ~c;
      wr(cfg_ofs[g] + 8, c);
      rd(cfg_ofs[g], v); chk("R2 clear alias", v, e);
      e = e ^ d;
      wr(cfg_ofs[g] + 12, d);
      rd(cfg_ofs[g], v); chk("R2 toggle alias", v, e);
      for (int k = 1; k < 4; k++) begin
        rd(cfg_ofs[g] + 4 * k, v); chk("R2 alias word reads 0", v, 32'd0);
      end
    end
    for (int g = 0; g < 13; g++) wr(cfg_ofs[g], (g == 0) ? 32'hFFFF_FFFF : 32'h0);

    // R11: constants and unmapped
    rd('h1F8, v); chk("R11 pin count", v, 32'd32);
    rd('h1FC, v); chk("R11 version", v, 32'h0001_0200);
    wr('h1F8, 32'hDEAD_BEEF);
    rd('h1F8, v); chk("R11 pin count read-only", v, 32'd32);
    rd('h0E0, v); chk("R11 unmapped", v, 32'd0);
    rd('h1A4, v); chk("R11 unmapped high", v, 32'd0);

    // R12: read data changes only at the edge
    rd('h1FC, v);
    @(negedge clk); bus_addr = 9'h1F8;
    #1 chk("R12 rdata holds before edge", bus_rdata, 32'h0001_0200);
    @(negedge clk); chk("R12 rdata after edge", bus_rdata, 32'd32);

    // R4: pin level word
    for (int p = 0; p < 5; p++) begin
      case (p)
        0: e = 32'h0000_0000;
        1: e = 32'hFFFF_FFFF;
        2: e = 32'hA5A5_5A5A;
        3: e = 32'h8000_0001;
        default: e = 32'h0000_0000;
      endcase
      @(negedge clk); pin_in = e;
      idle(3);
      rd('h060, v); chk("R4 pin level", v, e);
    end
    pin_in = 32'h0000_1000; idle(3);
    wr('h060, 32'hFFFF_0000);
    rd('h060, v); chk("R4 pin level write ignored", v, 32'h0000_1000);
    pin_in = '0; idle(4);
    wr('h0D8, 32'hFFFF_FFFF);
    rd('h0D0, v); chk("R6 all flags cleared", v, 32'd0);

    // R5 R6: every mode code against both directions
    for (int p = 0; p < 2; p++) begin
      int pin;
      pin = (p == 0) ? 3 : 30;
      for (int m = 0; m < 4; m++) begin
        wr('h0A0, m[0] ? (32'd1 << pin) : 32'd0);
        wr('h0B0, m[1] ? (32'd1 << pin) : 32'd0);
        wr('h0D8, 32'hFFFF_FFFF);
        @(negedge clk); pin_in[pin] = 1'b1;
        idle(5);
        rd('h0D0, v);
        chk("R5 rising edge flag", v, (m != 2) ? (32'd1 << pin) : 32'd0);
        wr('h0D0, 32'hFFFF_FFFF);
        wr('h0D4, 32'hFFFF_FFFF);
        wr('h0DC, 32'hFFFF_FFFF);
        rd('h0D0, v);
        chk("R6 other flag words ignored", v, (m != 2) ? (32'd1 << pin) : 32'd0);
        wr('h0D8, 32'd1 << pin);
        rd('h0D0, v); chk("R6 flag cleared", v, 32'd0);
        @(negedge clk); pin_in[pin] = 1'b0;
        idle(5);
        rd('h0D0, v);
        chk("R5 falling edge flag", v, (m != 1) ? (32'd1 << pin) : 32'd0);
        wr('h0D8, 32'hFFFF_FFFF);
      end
    end
    wr('h0A0, 32'd0);
    wr('h0B0, 32'd0);

    // R7: combined interrupt
    wr('h0D8, 32'hFFFF_FFFF);
    wr('h094, 32'd1 << 7);
    idle(2);
    chk("R7 irq idle", {31'd0, irq}, 32'd0);
    @(negedge clk); pin_in[7] = 1'b1;
    idle(5);
    chk("R7 irq on enabled flag", {31'd0, irq}, 32'd1);
    wr('h098, 32'd1 << 7);
    idle(1);
    chk("R7 irq off after disable", {31'd0, irq}, 32'd0);
    rd('h0D0, v); chk("R6 flag kept with enable off", v, 32'd1 << 7);
    wr('h0D8, 32'hFFFF_FFFF);
    @(negedge clk); pin_in[9] = 1'b1;
    idle(5);
    chk("R7 unenabled flag no irq", {31'd0, irq}, 32'd0);
    wr('h0D8, 32'hFFFF_FFFF);

    // R6: set beats clear in the same cycle
    @(negedge clk); pin_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = 9'h0D8; bus_we = 1'b1; bus_wdata = 32'd1 << 3;
    @(negedge clk); bus_we = 1'b0;
    rd('h0D0, v); chk("R6 set wins over clear", v, 32'd1 << 3);
    wr('h0D8, 32'hFFFF_FFFF);

    // R8: GPIO-owned pads
    for (int k = 0; k < 2; k++) begin
      a = k ? 32'h0F0F_A5A5 : 32'hFFFF_0000;
      b = k ? 32'h3C3C_FFFF : 32'h1234_5678;
      wr('h040, a);
      wr('h050, b);
      idle(2);
      chk("R8 pad_oe", pad_oe, a);
      chk("R8 pad_out", pad_out, b);
      wr('h05C, 32'hFFFF_FFFF);
      idle(2);
      chk("R8 pad_out toggled", pad_out, ~b);
    end
    wr('h040, 32'h0);
    wr('h050, 32'h0);

    // R9: peripheral-owned pin 5, all codes, one-hot and inverted lanes
    wr('h008, 32'd1 << 5);
    for (int f = 0; f < 8; f++) begin
      wr(f[0] ? 'h014 : 'h018, 32'd1 << 5);
      wr(f[1] ? 'h024 : 'h028, 32'd1 << 5);
      wr(f[2] ? 'h034 : 'h038, 32'd1 << 5);
      for (int inv = 0; inv < 2; inv++) begin
        logic [6:0] lane;
        lane = 7'(8'd1 << f);
        if (inv == 1) lane = ~lane;
        @(negedge clk);
        periph_dout[5*NF +: NF] = lane;
        periph_oe[5*NF +: NF]   = lane;
        idle(2);
        chk("R9 peripheral out", {31'd0, pad_out[5]}, {31'd0, (inv == 0) && (f < 7)});
        chk("R9 peripheral oe", {31'd0, pad_oe[5]}, {31'd0, (inv == 0) && (f < 7)});
      end
    end
    chk("R8 other pins stay GPIO", pad_oe & ~(32'd1 << 5), 32'd0);

    // R10: pad cell controls
    wr('h070, 32'hC0DE_0001);
    wr('h080, 32'h0BAD_F00D);
    wr('h160, 32'h7777_1111);
    idle(1);
    chk("R10 pull_up", pull_up, 32'hC0DE_0001);
    chk("R10 pull_dn", pull_dn, 32'h0BAD_F00D);
    chk("R10 schmitt_en", schmitt_en, 32'h7777_1111);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule